// File: doc/BRIEF.md
# Deferred Clock-Divide Mode Controller

The controller keeps a small software-programmable register that chooses how many fast pipeline-clock cycles make up one slow bus-clock cycle, and it produces a one-cycle clock-enable strobe at that rate. Software can write a new divide code at any time. The code stays pending in the register and the divider keeps running at its current ratio. The new ratio is adopted only when a wake-from-hibernate pulse arrives. At that moment the divide counter restarts, so the first period at the new ratio is complete.

There are two reset inputs. The power-on/RTC reset clears both the stored code and the active ratio, which puts the divider at divide-by-2. The ordinary system reset leaves the programmed code and the active ratio untouched and only restarts the divide counter. The register is 16 bits wide. Only its three low bits hold the code, and the remaining bits always read as zero.

Top module: `dmc_ctrl`

## Requirements
- R1: When `sel` is high, `rd_data` bits 15:3 read 0 and bits 2:0 carry the stored code. When `sel` is low, `rd_data` is all zero, and a pulse on `wr_en` leaves the stored code unchanged.
- R2: A write (`sel` and `wr_en` high at a clock edge) stores `wr_data[2:0]` and ignores `wr_data[15:3]`. Readback shows the last written code, even while the active ratio still differs from it.
- R3: A write on its own never changes `ratio`. `ratio` changes only on the clock edge that samples `wake` high.
- R4: At wake, `ratio` is loaded by decoding the stored code: 3'b001 gives 1, 3'b000 and 3'b010 give 2, and 3'b011 gives 3. `ratio` is a 2-bit binary count of pipeline cycles per bus cycle.
- R5: The codes 3'b100 to 3'b111 can be written and read back, but a wake with any of them stored loads a ratio of 2.
- R6: While `rtc_rst_n` is low (asynchronous, active low), the stored code is 3'b000, `ratio` is 2 and the divide counter is at zero.
- R7: A low `sys_rst_n` (synchronous, active low) keeps the stored code and `ratio` and clears the divide counter at the next edge.
- R8: With ratio N, `bus_ce` is high for exactly one pipeline cycle in every N. With N = 1 it is high every cycle. After a counter restart, the first strobe comes N-1 cycles after the restart edge.
- R9: The edge that samples `wake` restarts the divide counter, so the first strobe at the new ratio falls N-1 cycles after that edge.
- R10: When a write and a wake fall on the same edge, the wake loads the code stored before that edge, and the written code stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rtc_rst_n | input | 1 | Power-on/RTC reset, asynchronous, active low, clears the code |
| sys_rst_n | input | 1 | System reset, synchronous, active low, restarts the divider only |
| sel | input | 1 | Register address match |
| wr_en | input | 1 | Write strobe, acts only with `sel` |
| wr_data | input | 16 | Write data, bits 2:0 hold the code |
| wake | input | 1 | Wake-from-hibernate pulse that loads the active ratio |
| rd_data | output | 16 | Readback word |
| ratio | output | 2 | Active pipeline-to-bus clock ratio (1, 2 or 3) |
| bus_ce | output | 1 | Bus-clock enable strobe, one pipeline cycle wide |

## Verification
A corrupted stored code shows up on `rd_data` during the very next selected read. Unless software rewrites the code first, it also reaches `ratio` at the next wake. A wrong active ratio or a wrong counter value shows up in the `bus_ce` spacing within at most three pipeline cycles. The bench model follows the code, the ratio and the counter position one cycle at a time, so any such fault is reported on the first cycle where the port values differ.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
   localparam int unsigned CODE_W  = 3;
   localparam int unsigned RATIO_W = 2;

   typedef logic [CODE_W-1:0]  code_t;
   typedef logic [RATIO_W-1:0] ratio_t;

   localparam code_t  CODE_RESET    = 3'b000;
   localparam ratio_t RATIO_DEFAULT = 2'd2;

   // Map a divide code to pipeline cycles per bus cycle; anything not
   // explicitly defined falls back to the default ratio.
   function automatic ratio_t decode_code(input code_t code);
      case (code)
         3'b001:  return 2'd1;
         3'b010:  return 2'd2;
         3'b011:  return 2'd3;
         default: return RATIO_DEFAULT;
      endcase
   endfunction
endpackage

// File: rtl/dmc_field_reg.sv
`timescale 1ns/1ps
module dmc_field_reg
   import dmc_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rtc_rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output code_t             code_q,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned PAD_W = DATA_W - CODE_W;

   if (DATA_W < CODE_W) begin : g_bad_width
      $error("dmc_field_reg: DATA_W must hold the code field");
   end

   logic wr_hit;
   assign wr_hit = sel & wr_en;

   always_ff @(posedge clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n)  code_q <= CODE_RESET;
      else if (wr_hit) code_q <= wr_data[CODE_W-1:0];
   end

   logic [DATA_W-1:0] word;
   if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[DATA_W-1:CODE_W];
      assign word = {{PAD_W{1'b0}}, code_q};
   end else begin : g_exact
      assign word = code_q;
   end

   assign rd_data = sel ? word : '0;

   // R1 / R2: code only moves on a selected write
   assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      !wr_hit |=> $stable(code_q));
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      wr_hit |=> code_q == $past(wr_data[CODE_W-1:0]));
   always_comb begin
      if (PAD_W > 0)
         assert_upper_zero_R1: assert ((rd_data >> CODE_W) == '0);
   end
endmodule

// File: rtl/dmc_ratio_reg.sv
`timescale 1ns/1ps
module dmc_ratio_reg
   import dmc_pkg::*;
(
   input  logic   clk,
   input  logic   rtc_rst_n,
   input  logic   wake,
   input  code_t  code,
   output ratio_t ratio_q
);
   ratio_t ratio_next;
   assign ratio_next = decode_code(code);

   always_ff @(posedge clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) ratio_q <= RATIO_DEFAULT;
      else if (wake)  ratio_q <= ratio_next;
   end

   assert_no_wake_stable_R3: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      !wake |=> $stable(ratio_q));
   assert_ratio_legal_R5: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      ratio_q != 2'd0);
   assert_reserved_default_R5: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      (wake && code[CODE_W-1]) |=> ratio_q == RATIO_DEFAULT);
endmodule

// File: rtl/dmc_ce_gen.sv
`timescale 1ns/1ps
module dmc_ce_gen
   import dmc_pkg::*;
(
   input  logic   clk,
   input  logic   rtc_rst_n,
   input  logic   sys_rst_n,
   input  logic   wake,
   input  ratio_t ratio,
   output logic   bus_ce
);
   ratio_t cnt_q;
   ratio_t last_pos;

   assign last_pos = RATIO_W'(ratio - 1'b1);
   assign bus_ce   = (cnt_q == last_pos);

   always_ff @(posedge clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n)               cnt_q <= '0;
      else if (!sys_rst_n || wake)  cnt_q <= '0;
      else if (bus_ce)              cnt_q <= '0;
      else                          cnt_q <= RATIO_W'(cnt_q + 1'b1);
   end

   assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      cnt_q < ratio);
   assert_strobe_gap_R8: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      (bus_ce && ratio != 2'd1 && !wake) |=> !bus_ce);
   assert_wake_restart_R9: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      wake |=> cnt_q == '0);
   assert_sysrst_restart_R7: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      !sys_rst_n |=> cnt_q == '0);
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rtc_rst_n,
   input  logic              sys_rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wake,
   output logic [DATA_W-1:0] rd_data,
   output logic [RATIO_W-1:0] ratio,
   output logic              bus_ce
);
   code_t  code_q;
   ratio_t ratio_q;

   dmc_field_reg #(.DATA_W(DATA_W)) u_field (
      .clk(clk), .rtc_rst_n(rtc_rst_n), .sel(sel), .wr_en(wr_en),
      .wr_data(wr_data), .code_q(code_q), .rd_data(rd_data)
   );

   dmc_ratio_reg u_ratio (
      .clk(clk), .rtc_rst_n(rtc_rst_n), .wake(wake),
      .code(code_q), .ratio_q(ratio_q)
   );

   dmc_ce_gen u_ce (
      .clk(clk), .rtc_rst_n(rtc_rst_n), .sys_rst_n(sys_rst_n),
      .wake(wake), .ratio(ratio_q), .bus_ce(bus_ce)
   );

   assign ratio = ratio_q;

   // R10: wake loads the code held before a coincident write
   assert_wake_uses_old_R10: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      wake |=> ratio == decode_code($past(code_q)));
   assert_sysrst_keeps_R7: assert property (@(posedge clk) disable iff (!rtc_rst_n)
      (!sys_rst_n && !wake) |=> $stable(ratio));
endmodule

// File: tb/sim_dmc_ctrl.sv
`timescale 1ns/1ps
module sim_dmc_ctrl;
   logic        clk = 1'b0;
   logic        rtc_rst_n = 1'b0, sys_rst_n = 1'b0;
   logic        sel = 1'b0, wr_en = 1'b0, wake = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [1:0]  ratio;
   logic        bus_ce;

   int vectors = 0, fails = 0;
   string tag = "R6";

   // reference state
   int m_code = 0, m_ratio = 2, m_cnt = 0, m_sel = 0;

   always #2.5 clk = ~clk;

   dmc_ctrl u0 (
      .clk(clk), .rtc_rst_n(rtc_rst_n), .sys_rst_n(sys_rst_n), .sel(sel),
      .wr_en(wr_en), .wr_data(wr_data), .wake(wake), .rd_data(rd_data),
      .ratio(ratio), .bus_ce(bus_ce)
   );

   function automatic int dec(int c);
      if (c == 1) return 1;
      if (c == 3) return 3;
      return 2;
   endfunction

   task automatic check(string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(int s, int we, int d, int wk, int rtcn, int sysn);
      int nc;
      @(negedge clk);
      check("rd_data", int'(rd_data), (m_sel != 0) ? m_code : 0);
      check("ratio", int'(ratio), m_ratio);
      check("bus_ce", int'(bus_ce), (m_cnt == m_ratio - 1) ? 1 : 0);
      sel = s[0]; wr_en = we[0]; wr_data = d[15:0]; wake = wk[0];
      rtc_rst_n = rtcn[0]; sys_rst_n = sysn[0];
      m_sel = s;
      if (rtcn == 0) begin
         m_code = 0; m_ratio = 2; m_cnt = 0;
      end else begin
         if (sysn == 0 || wk != 0)       nc = 0;
         else if (m_cnt == m_ratio - 1)  nc = 0;
         else                            nc = m_cnt + 1;
         if (wk != 0) m_ratio = dec(m_code);
         if (s != 0 && we != 0) m_code = d & 7;
         m_cnt = nc;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, 1, 1);
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int lf;
      // R6: both resets low, then release
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
      step(1, 0, 0, 0, 1, 1);
      tag = "R8"; idle(8);
      // R2 / R3: write div-3 code with upper bits set, ratio stays
      tag = "R2"; step(1, 1, 16'hFFFB, 0, 1, 1);
      tag = "R3"; idle(6);
      // R9 / R4: wake adopts 3
      tag = "R9"; step(1, 0, 0, 1, 1, 1); idle(9);
      tag = "R4"; step(1, 1, 1, 0, 1, 1); step(1, 0, 0, 1, 1, 1); idle(5);
      step(1, 1, 2, 0, 1, 1); step(1, 0, 0, 1, 1, 1); idle(5);
      // R5: reserved codes
      tag = "R5";
      for (int c = 4; c < 8; c++) begin
         step(1, 1, c, 0, 1, 1); step(1, 0, 0, 1, 1, 1); idle(4);
         step(1, 1, 3, 0, 1, 1); step(1, 0, 0, 1, 1, 1); idle(4);
      end
      tag = "R4"; step(1, 1, 0, 0, 1, 1); step(1, 0, 0, 1, 1, 1); idle(5);
      // R10: write and wake together
      tag = "R10"; step(1, 1, 3, 1, 1, 1); idle(5);
      step(1, 0, 0, 1, 1, 1); idle(6);
      // R7: system reset keeps code and ratio, restarts counter
      tag = "R7"; idle(1);
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1, 0);
      idle(7);
      // R1: unselected read and write
      tag = "R1"; step(0, 1, 1, 0, 1, 1); idle(2); step(0, 0, 0, 0, 1, 1); idle(2);
      // R6: RTC reset clears code and ratio
      tag = "R6"; step(1, 0, 0, 0, 0, 1); step(1, 0, 0, 0, 0, 1); idle(5);
      // mixed traffic
      tag = "R8"; lf = 32'h1D2C3B4A;
      for (int i = 0; i < 400; i++) begin
         lf = (lf << 1) ^ (((lf >>> 31) & 1) != 0 ? 32'h04C11DB7 : 0);
         step(((lf >> 3) & 3) != 0 ? 1 : 0, (lf >> 5) & 1, (lf >> 8) & 16'hFFFF,
              ((lf >> 12) & 7) == 0 ? 1 : 0, ((lf >> 16) & 127) != 0 ? 1 : 0,
              ((lf >> 24) & 31) != 0 ? 1 : 0);
      end
      idle(2);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule